// File: doc/BRIEF.md
# Sequential Fixed-Point Radix Converter

This block takes an unsigned fixed-point number, made of an integer field and a binary fraction field, and writes it out as a string of digits in radix 2, 8, 10 or 16. A single start pulse captures the operands and the radix. After that, the block sends the digits one at a time on a valid/ready stream. The whole-number digits come first, most significant digit first. The fraction digits follow, starting with the digit just right of the radix point. Each digit carries a tag that says whether it belongs to the integer part or the fraction part. The final digit also carries an end marker.

The integer field is taken apart by repeated division by the radix. Each remainder is one digit, and the least significant digit comes out first. For radix 10 the division is a restoring divider that produces one quotient bit per cycle. For radices that are powers of two it is a shift and a mask that take one cycle. The remainders are held on a small stack and are then popped in reverse order. The fraction is built by repeated multiplication by the radix. The bits that overflow above the binary point form the next digit. This stops once the remaining fraction is zero, or once a parameter limit on fraction digits has been reached. Each digit is given both as a 4-bit value and as an ASCII character.

Top module: `radix_converter`

## Requirements
- R1: The integer digits equal the base-r representation of the integer field with no leading zeros, and they come out most significant first.
- R2: An integer field of zero produces exactly one integer digit, of value 0.
- R3: Fraction digits come out in order of decreasing weight. Digit k is the integer part of r times the fraction left after the step before it.
- R4: Fraction digits stop at the first step that leaves a zero remainder. A zero fraction field produces no fraction digits at all.
- R5: No more than MAX_FRAC fraction digits are produced, even when the fraction has not yet reached zero.
- R6: The radix select input is decoded as follows: 0 gives radix 2, 1 gives 8, 2 gives 10 and 3 gives 16. Every digit sent is smaller than the selected radix.
- R7: The character output is ASCII '0' to '9' for digit values 0 to 9, and 'A' to 'F' for values 10 to 15.
- R8: The fraction tag is 0 on integer digits and 1 on fraction digits. The last marker is 1 on the final digit of a conversion and only on that digit.
- R9: While a digit is valid and ready is low, the valid signal, the digit value, the tag and the last marker all stay unchanged.
- R10: busy goes high in the cycle after an accepted start. It stays high until the last digit has been taken. A start that arrives while busy is high has no effect on the digit stream.
- R11: done is high for exactly one cycle: the cycle right after the digit marked last is accepted.
- R12: During and after reset, busy, done and digit valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a conversion; taken only while idle |
| int_i | input | INT_W | Integer field of the operand |
| frac_i | input | FRAC_W | Fraction field of the operand (binary weights 2^-1 down) |
| radix_i | input | 2 | Radix select: 0=2, 1=8, 2=10, 3=16 |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle pulse after the final digit is taken |
| dig_valid_o | output | 1 | A digit is on offer |
| dig_ready_i | input | 1 | The consumer takes the digit this cycle |
| dig_val_o | output | 4 | Digit value |
| dig_char_o | output | 8 | ASCII character for the digit |
| dig_frac_o | output | 1 | Set when the digit is part of the fraction |
| dig_last_o | output | 1 | Set on the final digit of the conversion |

## Verification
Some rules are checked by the assertions on every cycle:
- A stalled digit stays stable, along with its tag and last marker.
- done fires only after a last digit has been accepted, and only as a single-cycle pulse.
- busy rises after an accepted start.
- Every digit sent is below the captured radix.
- Once the fraction has begun, the stream stays in the fraction part.

Other behaviour can only be shown by the bench's scenarios:
- the correct digit sequence and its order;
- the single zero digit for a zero integer field;
- the stop at a zero remainder versus the stop at the digit limit;
- the character mapping;
- that a start arriving mid-conversion is ignored.

// File: rtl/radix_conv_pkg.sv
// Shared types and helpers for the radix converter.
// Assumes digit values never exceed 15 (largest radix is 16).
package radix_conv_pkg;

    typedef enum logic [1:0] {
        RAD_BIN = 2'd0,
        RAD_OCT = 2'd1,
        RAD_DEC = 2'd2,
        RAD_HEX = 2'd3
    } radix_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_INT_OUT,
        ST_FRAC_OUT,
        ST_DONE
    } conv_state_e;

    // Numeric value of a radix code.
    function automatic logic [4:0] radix_value(input radix_e r);
        case (r)
            RAD_BIN: radix_value = 5'd2;
            RAD_OCT: radix_value = 5'd8;
            RAD_DEC: radix_value = 5'd10;
            default: radix_value = 5'd16;
        endcase
    endfunction

    // Shift amount for power-of-two radices, zero when a real divide is needed.
    function automatic logic [2:0] radix_shift(input radix_e r);
        case (r)
            RAD_BIN: radix_shift = 3'd1;
            RAD_OCT: radix_shift = 3'd3;
            RAD_DEC: radix_shift = 3'd0;
            default: radix_shift = 3'd4;
        endcase
    endfunction

    // ASCII glyph for a digit value 0..15.
    function automatic logic [7:0] digit_char(input logic [3:0] d);
        if (d < 4'd10) digit_char = 8'h30 + {4'h0, d};
        else           digit_char = 8'h37 + {4'h0, d};
    endfunction

endpackage

// File: rtl/rc_int_divider.sv
// Divides the integer field by the radix, giving quotient and remainder.
// Power-of-two radices finish in one cycle by shift and mask; radix 10
// runs a restoring divider for INT_W cycles. fin_o pulses for one cycle
// when quo_o/rem_o are valid. Assumes INT_W >= 4 and go_i only while idle.
module rc_int_divider
    import radix_conv_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [INT_W-1:0] num_i,
    input  radix_e           rad_i,
    output logic [INT_W-1:0] quo_o,
    output logic [3:0]       rem_o,
    output logic             fin_o
);
    localparam int CNT_W = $clog2(INT_W + 1);

    logic [INT_W-1:0] quo_q;
    logic [3:0]       rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             fin_q;
    radix_e           rad_q;

    logic [2:0] go_sh;
    logic [3:0] go_mask;
    logic [4:0] shifted;
    logic [5:0] trial;
    logic       trial_ok;

    // Shortcut decode and one restoring step.
    always_comb begin
        go_sh    = radix_shift(rad_i);
        go_mask  = 4'((5'd1 << go_sh) - 5'd1);
        shifted  = {rem_q, quo_q[INT_W-1]};
        trial    = {1'b0, shifted} - {1'b0, radix_value(rad_q)};
        trial_ok = ~trial[5];
    end

    // Load operands, or advance the divider by one quotient bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
            rad_q <= RAD_BIN;
        end else begin
            fin_q <= 1'b0;
            if (go_i) begin
                rad_q <= rad_i;
                if (go_sh != 3'd0) begin
                    quo_q <= num_i >> go_sh;
                    rem_q <= num_i[3:0] & go_mask;
                    fin_q <= 1'b1;
                    run_q <= 1'b0;
                end else begin
                    quo_q <= num_i;
                    rem_q <= '0;
                    cnt_q <= CNT_W'(INT_W);
                    run_q <= 1'b1;
                end
            end else if (run_q) begin
                quo_q <= {quo_q[INT_W-2:0], trial_ok};
                rem_q <= trial_ok ? trial[3:0] : shifted[3:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;
    assign fin_o = fin_q;
endmodule

// File: rtl/rc_digit_stack.sv
// Last-in first-out store for integer digits, so that the remainders
// produced least significant first leave most significant first.
// Assumes the caller never pushes when full or pops when empty.
module rc_digit_stack #(
    parameter int DEPTH = 8,
    parameter int DW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [DW-1:0] din_i,
    input  logic          pop_i,
    output logic [DW-1:0] top_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;

    // Track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (push_i)     cnt_q <= cnt_q + 1'b1;
        else if (pop_i)      cnt_q <= cnt_q - 1'b1;
    end

    // Write a pushed digit into the next free slot.
    always_ff @(posedge clk) begin
        if (push_i) mem[AW'(cnt_q)] <= din_i;
    end

    assign top_o   = mem[AW'(cnt_q - 1'b1)];
    assign count_o = cnt_q;
endmodule

// File: rtl/rc_frac_step.sv
// One multiply step of the fraction: the bits above the binary point of
// frac*r form the digit, the rest is the new fraction. Purely combinational.
module rc_frac_step
    import radix_conv_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  radix_e            rad_i,
    output logic [3:0]        digit_o,
    output logic [FRAC_W-1:0] rest_o
);
    localparam int PW = FRAC_W + 4;

    logic [PW-1:0] prod;

    // Scale the fraction by the radix and split it at the binary point.
    always_comb begin
        prod    = PW'(frac_i) * PW'(radix_value(rad_i));
        digit_o = prod[PW-1:FRAC_W];
        rest_o  = prod[FRAC_W-1:0];
    end
endmodule

// File: rtl/radix_converter.sv
// Top of the fixed-point radix converter. It captures the operands on start,
// fills the digit stack through the divider, drains the stack as integer
// digits, then sends fraction digits until the remainder is zero or
// MAX_FRAC digits have gone. Assumes MAX_FRAC >= 1 and INT_W >= 4.
module radix_converter
    import radix_conv_pkg::*;
#(
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 8,
    parameter int MAX_FRAC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [1:0]        radix_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              dig_valid_o,
    input  logic              dig_ready_i,
    output logic [3:0]        dig_val_o,
    output logic [7:0]        dig_char_o,
    output logic              dig_frac_o,
    output logic              dig_last_o
);
    localparam int FCW = $clog2(MAX_FRAC + 1);
    localparam int SCW = $clog2(INT_W + 1);

    conv_state_e       state_q;
    radix_e            rad_q;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FCW-1:0]    fcnt_q;

    logic              div_go, div_fin;
    logic [INT_W-1:0]  div_quo;
    logic [3:0]        div_rem;
    logic              stk_push, stk_pop, stk_clr;
    logic [3:0]        stk_top;
    logic [SCW-1:0]    stk_cnt;
    logic [3:0]        f_digit;
    logic [FRAC_W-1:0] f_rest;
    logic              fire;

    rc_int_divider #(.INT_W(INT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (int_q),
        .rad_i (rad_q),
        .quo_o (div_quo),
        .rem_o (div_rem),
        .fin_o (div_fin)
    );

    rc_digit_stack #(.DEPTH(INT_W), .DW(4)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (stk_clr),
        .push_i  (stk_push),
        .din_i   (div_rem),
        .pop_i   (stk_pop),
        .top_o   (stk_top),
        .count_o (stk_cnt)
    );

    rc_frac_step #(.FRAC_W(FRAC_W)) u_frac (
        .frac_i  (frac_q),
        .rad_i   (rad_q),
        .digit_o (f_digit),
        .rest_o  (f_rest)
    );

    // Digit stream drive and sub-block strobes, decoded from the state.
    always_comb begin
        dig_valid_o = 1'b0;
        dig_val_o   = 4'd0;
        dig_frac_o  = 1'b0;
        dig_last_o  = 1'b0;
        case (state_q)
            ST_INT_OUT: begin
                dig_valid_o = 1'b1;
                dig_val_o   = stk_top;
                dig_last_o  = (stk_cnt == SCW'(1)) && (frac_q == '0);
            end
            ST_FRAC_OUT: begin
                dig_valid_o = 1'b1;
                dig_val_o   = f_digit;
                dig_frac_o  = 1'b1;
                dig_last_o  = (f_rest == '0) || (fcnt_q == FCW'(MAX_FRAC - 1));
            end
            default: ;
        endcase
        fire       = dig_valid_o && dig_ready_i;
        dig_char_o = digit_char(dig_val_o);
        div_go     = (state_q == ST_DIV_GO);
        stk_push   = (state_q == ST_DIV_WAIT) && div_fin;
        stk_pop    = (state_q == ST_INT_OUT) && fire;
        stk_clr    = (state_q == ST_IDLE) && start_i;
        busy_o     = (state_q != ST_IDLE);
        done_o     = (state_q == ST_DONE);
    end

    // Sequencer: capture, divide loop, integer drain, fraction steps, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rad_q   <= RAD_BIN;
            int_q   <= '0;
            frac_q  <= '0;
            fcnt_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    rad_q   <= radix_e'(radix_i);
                    int_q   <= int_i;
                    frac_q  <= frac_i;
                    fcnt_q  <= '0;
                    state_q <= ST_DIV_GO;
                end
                ST_DIV_GO: state_q <= ST_DIV_WAIT;
                ST_DIV_WAIT: if (div_fin) begin
                    int_q   <= div_quo;
                    state_q <= (div_quo == '0) ? ST_INT_OUT : ST_DIV_GO;
                end
                ST_INT_OUT: if (fire && stk_cnt == SCW'(1)) begin
                    state_q <= (frac_q == '0) ? ST_DONE : ST_FRAC_OUT;
                end
                ST_FRAC_OUT: if (fire) begin
                    frac_q <= f_rest;
                    fcnt_q <= fcnt_q + 1'b1;
                    if (dig_last_o) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/radix_converter_chk.sv
// Protocol and range checks for the radix converter, bound to the top.
module radix_converter_chk
    import radix_conv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] rad_cap,
    input logic       busy_o,
    input logic       done_o,
    input logic       dig_valid_o,
    input logic       dig_ready_i,
    input logic [3:0] dig_val_o,
    input logic       dig_frac_o,
    input logic       dig_last_o
);
    a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o && !dig_ready_i |=> dig_valid_o && $stable(dig_val_o)
            && $stable(dig_frac_o) && $stable(dig_last_o));

    a_r11_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(dig_valid_o && dig_ready_i && dig_last_o));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    a_r6_digit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o |-> ({1'b0, dig_val_o} < radix_value(radix_e'(rad_cap))));

    a_r8_frac_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dig_valid_o && dig_ready_i && dig_frac_o && !dig_last_o |=> dig_valid_o && dig_frac_o);
endmodule

bind radix_converter radix_converter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rad_cap     (rad_q),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .dig_valid_o (dig_valid_o),
    .dig_ready_i (dig_ready_i),
    .dig_val_o   (dig_val_o),
    .dig_frac_o  (dig_frac_o),
    .dig_last_o  (dig_last_o)
);

// File: tb/test_radix_converter.sv
module test_radix_converter;
    localparam int CLK_PERIOD = 10;
    localparam int INT_W = 8, FRAC_W = 8, MAX_FRAC = 6;
    localparam int NV = 11;

    // {int, frac, radix code, expected int digit count, expected frac digit count}
    localparam int VEC [NV][5] = '{
        '{58,  8'h40, 0, 6, 2},
        '{58,  8'h40, 1, 2, 1},
        '{58,  8'h40, 2, 2, 2},
        '{58,  8'h40, 3, 2, 1},
        '{0,   8'h00, 2, 1, 0},
        '{255, 8'h00, 0, 8, 0},
        '{255, 8'hFF, 3, 2, 2},
        '{0,   8'h1A, 2, 1, 6},
        '{200, 8'h01, 0, 8, 6},
        '{100, 8'h80, 2, 3, 1},
        '{7,   8'h01, 1, 1, 3}
    };

    logic clk = 0, rst_n = 0, start_i = 0, dig_ready_i = 0;
    logic [INT_W-1:0] int_i = '0;
    logic [FRAC_W-1:0] frac_i = '0;
    logic [1:0] radix_i = '0;
    logic busy_o, done_o, dig_valid_o, dig_frac_o, dig_last_o;
    logic [3:0] dig_val_o;
    logic [7:0] dig_char_o;

    int n_checks = 0, n_fail = 0, cycles = 0;
    int got_val[32], got_frac[32], got_last[32], got_char[32], ng;
    int exp_val[32], exp_ni, exp_nf;

    always #(CLK_PERIOD/2) clk = ~clk;

    radix_converter #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MAX_FRAC(MAX_FRAC)) i_radix_converter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_i(int_i), .frac_i(frac_i),
        .radix_i(radix_i), .busy_o(busy_o), .done_o(done_o), .dig_valid_o(dig_valid_o),
        .dig_ready_i(dig_ready_i), .dig_val_o(dig_val_o), .dig_char_o(dig_char_o),
        .dig_frac_o(dig_frac_o), .dig_last_o(dig_last_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rad_of(input int code);
        case (code)
            0: return 2;
            1: return 8;
            2: return 10;
            default: return 16;
        endcase
    endfunction

    // Reference digits from plain integer arithmetic.
    task automatic ref_digits(input int iv, input int fv, input int code);
        int r = rad_of(code);
        int tmp = iv;
        int rev[32];
        int n = 0;
        int f = fv;
        do begin
            rev[n] = tmp % r;
            tmp = tmp / r;
            n++;
        end while (tmp != 0);
        exp_ni = n;
        for (int i = 0; i < n; i++) exp_val[i] = rev[n-1-i];
        exp_nf = 0;
        while (f != 0 && exp_nf < MAX_FRAC) begin
            f = f * r;
            exp_val[n + exp_nf] = f / 256;
            f = f % 256;
            exp_nf++;
        end
    endtask

    task automatic run_conv(input int iv, input int fv, input int code,
                            input bit stall, input bit inject);
        int cyc = 0;
        bit fin = 0, held = 0, busy_ok = 1;
        logic [3:0] held_val = '0;
        ref_digits(iv, fv, code);
        ng = 0;
        @(negedge clk);
        start_i = 1; int_i = INT_W'(iv); frac_i = FRAC_W'(fv); radix_i = 2'(code);
        dig_ready_i = 0;
        @(negedge clk);
        start_i = 0;
        chk(busy_o === 1'b1, "R10 busy after start", int'(busy_o), 1);
        while (!fin && cyc < 2000) begin
            if (held) begin
                chk(dig_valid_o && dig_val_o == held_val, "R9 stalled digit held",
                    int'(dig_val_o), int'(held_val));
                held = 0;
            end
            if (inject && cyc == 3) begin
                start_i = 1; int_i = 8'h99; frac_i = 8'h11; radix_i = 2'd3;
            end else start_i = 0;
            dig_ready_i = stall ? (cyc % 3 == 2) : 1'b1;
            if (!busy_o) busy_ok = 0;
            if (dig_valid_o && dig_ready_i) begin
                got_val[ng] = int'(dig_val_o); got_frac[ng] = int'(dig_frac_o);
                got_last[ng] = int'(dig_last_o); got_char[ng] = int'(dig_char_o);
                ng++;
                if (dig_last_o) fin = 1;
            end else if (dig_valid_o) begin
                held = 1; held_val = dig_val_o;
            end
            @(negedge clk);
            cyc++;
        end
        start_i = 0; dig_ready_i = 0;
        chk(fin, "R8 last marker seen", int'(fin), 1);
        chk(busy_ok, "R10 busy held until last taken", int'(busy_ok), 1);
        chk(done_o === 1'b1, "R11 done after last", int'(done_o), 1);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R11 done one cycle", int'(done_o), 0);
        chk(ng == exp_ni + exp_nf, "R1/R4/R5 digit count", ng, exp_ni + exp_nf);
        for (int i = 0; i < ng && i < exp_ni + exp_nf; i++) begin
            int ec = (exp_val[i] < 10) ? 48 + exp_val[i] : 55 + exp_val[i];
            chk(got_val[i] == exp_val[i], (i < exp_ni) ? "R1 integer digit" : "R3 fraction digit",
                got_val[i], exp_val[i]);
            chk(got_frac[i] == ((i >= exp_ni) ? 1 : 0), "R8 fraction tag", got_frac[i], int'(i >= exp_ni));
            chk(got_last[i] == ((i == ng - 1) ? 1 : 0), "R8 last position", got_last[i], int'(i == ng - 1));
            chk(got_char[i] == ec, "R7 character", got_char[i], ec);
            chk(got_val[i] < rad_of(code), "R6 digit below radix", got_val[i], rad_of(code));
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !dig_valid_o, "R12 reset state", int'(busy_o | done_o | dig_valid_o), 0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_conv(VEC[v][0], VEC[v][1], VEC[v][2], v[0], 1'b0);
            chk(exp_ni == VEC[v][3], "R1 reference integer count", exp_ni, VEC[v][3]);
            chk(exp_nf == VEC[v][4], "R4/R5 reference fraction count", exp_nf, VEC[v][4]);
        end

        // 58.25 in radix 16 reads 3A.4 (R6 code 3, R7 letter)
        run_conv(58, 8'h40, 3, 1'b0, 1'b0);
        chk(got_char[0] == 8'h33 && got_char[1] == 8'h41 && got_char[2] == 8'h34,
            "R7 hex text 3A.4", got_char[1], 8'h41);
        // 58.25 in radix 8 reads 72.2 (R6 code 1)
        run_conv(58, 8'h40, 1, 1'b0, 1'b0);
        chk(got_val[0] == 7 && got_val[1] == 2 && got_val[2] == 2 && ng == 3,
            "R6 octal 72.2", got_val[0], 7);
        // zero integer gives one digit 0
        run_conv(0, 8'h80, 0, 1'b0, 1'b0);
        chk(ng == 2 && got_val[0] == 0 && got_frac[0] == 0, "R2 zero integer single digit", ng, 2);
        // fraction cut at the digit limit
        run_conv(0, 8'h1A, 2, 1'b1, 1'b0);
        chk(ng == 1 + MAX_FRAC && got_val[6] == 2, "R5 fraction limit", ng, 1 + MAX_FRAC);
        // a start during a conversion is ignored
        run_conv(58, 8'h40, 0, 1'b1, 1'b1);
        chk(ng == 8 && got_val[0] == 1, "R10 start ignored while busy", ng, 8);
        chk(!busy_o && !dig_valid_o, "R10 idle after run", int'(busy_o), 0);

        // reset in the middle of a stalled stream
        @(negedge clk);
        start_i = 1; int_i = 8'd255; frac_i = 8'h00; radix_i = 2'd0; dig_ready_i = 0;
        @(negedge clk);
        start_i = 0;
        repeat (20) @(negedge clk);
        chk(dig_valid_o === 1'b1, "R9 digit waits for ready", int'(dig_valid_o), 1);
        rst_n = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && !dig_valid_o, "R12 reset mid stream", int'(busy_o | dig_valid_o), 0);
        rst_n = 1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule